// File: doc/BRIEF.md
# Two-Slot DRAM Command Issuer

This block sits between user request channels and a reduced-latency DRAM PHY that takes two command slots on every fabric clock. Reads, writes and user refreshes arrive on separate valid/ready channels. Each cycle the block picks at most one command for slot 0 and at most one refresh for slot 1. It drives per-slot select, write-enable, refresh, address and bank outputs from registers, so a command accepted at a clock edge shows on the slot outputs for the following cycle. Write data and mask follow their command on the data outputs two cycles later.

Until the PHY reports calibration done, every slot carries a NOP and no request is accepted. After that, a per-bank busy timer keeps commands to one bank at least `TRC` cycles apart. An internal refresh pacer raises a due flag at a fixed interval. While the flag is up, reads and writes stall and slot 0 refreshes the banks in rotation. A mode input selects burst-length-four operation, in which a read or write in slot 0 leaves slot 1 empty.

Top module: `cmd_slot_issuer`

## Requirements
- R1: While `cal_done` is low, all three ready outputs are low, and both slots show NOP (select, write-enable and refresh all 0, address and bank 0) in the following cycle.
- R2: A write accepted at an edge shows in the next cycle as slot 0 select=1, write-enable=1, refresh=0, with the request's address and bank.
- R3: A read accepted at an edge shows in the next cycle as slot 0 select=1, write-enable=0, refresh=0, with the request's address and bank.
- R4: A refresh slot shows select=1, write-enable=0, refresh=1, the target bank, and address 0. An empty slot shows all zeros. Slot 1 carries only refreshes, taken from the user refresh channel.
- R5: With `bl4_mode` high, a cycle whose slot 0 carries a read or write has slot 1 as NOP, and the user refresh channel is not ready in the accepting cycle. With `bl4_mode` low, a user refresh may share the cycle with a read or write to a different bank.
- R6: Two cycles after a write shows on slot 0, `wd_en0` and `wd_en1` are both 1. In that cycle, slot 0 data/mask carry the low halves of the write's `wr_data`/`wr_mask` and slot 1 carries the high halves. Writes in consecutive cycles each get their own data. At all other times the enables, data and masks are 0.
- R7: A write takes slot 0 ahead of a read: `rd_ready` is low in any cycle in which a write is accepted.
- R8: Two refreshes in one cycle (internal in slot 0, user in slot 1) always target different banks, both of which are free.
- R9: Two commands on any slots to the same bank are at least `TRC` cycles apart. A request whose bank is busy is not ready.
- R10: After `REF_INT` consecutive calibrated cycles a refresh becomes due. While it is due, `wr_ready` and `rd_ready` are low. The due refresh issues in slot 0 as soon as its bank is free, targeting banks 0, 1, 2, … in rotation. Dropping `cal_done` clears the due flag and restarts the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_done | input | 1 | PHY calibration complete |
| bl4_mode | input | 1 | 1 = burst-length-four slot rule |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when valid |
| wr_addr | input | ADDR_W | Write address |
| wr_bank | input | BANK_W | Write bank |
| wr_data | input | 2*DQ_W | Write data, low half to slot 0 |
| wr_mask | input | 2*DM_W | Write mask, low half to slot 0 |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when valid |
| rd_addr | input | ADDR_W | Read address |
| rd_bank | input | BANK_W | Read bank |
| rf_valid | input | 1 | User refresh request valid |
| rf_ready | output | 1 | User refresh accepted when valid |
| rf_bank | input | BANK_W | User refresh bank |
| s0_sel | output | 1 | Slot 0 chip select |
| s0_wen | output | 1 | Slot 0 write enable |
| s0_ref | output | 1 | Slot 0 refresh |
| s0_addr | output | ADDR_W | Slot 0 address |
| s0_bank | output | BANK_W | Slot 0 bank |
| s1_sel | output | 1 | Slot 1 chip select |
| s1_wen | output | 1 | Slot 1 write enable (always 0) |
| s1_ref | output | 1 | Slot 1 refresh |
| s1_addr | output | ADDR_W | Slot 1 address (always 0) |
| s1_bank | output | BANK_W | Slot 1 bank |
| wd_en0 | output | 1 | Slot 0 write-data enable |
| wd_en1 | output | 1 | Slot 1 write-data enable |
| wd_data0 | output | DQ_W | Slot 0 write data |
| wd_data1 | output | DQ_W | Slot 1 write data |
| wd_mask0 | output | DM_W | Slot 0 data mask |
| wd_mask1 | output | DM_W | Slot 1 data mask |

## Verification
The slot logic is driven with three request mixes: calibration held low with every channel valid, dense random traffic on few banks with `bl4_mode` high, and the same traffic with `bl4_mode` low. The first mix separates the calibration gate from the other stall causes. The two random mixes show whether slot 1 pairing follows the mode, and the bank collisions in them exercise the busy timers and the rule that paired refreshes use different banks. A directed run of writes in consecutive cycles shows whether the data pipeline keeps each word tied to its own command. Calibration is dropped and restored partway through, so the refresh interval restart and the rotation order are both compared against the model.

// File: rtl/slot_issue_pkg.sv
package slot_issue_pkg;

  typedef enum logic [1:0] {
    CK_NOP = 2'd0,
    CK_RD  = 2'd1,
    CK_WR  = 2'd2,
    CK_REF = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    logic sel;
    logic wen;
    logic rf;
  } slot_ctl_t;

  // Control-line encoding of one slot for each command kind.
  function automatic slot_ctl_t ctl_of(cmd_kind_e k);
    slot_ctl_t c;
    case (k)
      CK_RD:   c = '{sel: 1'b1, wen: 1'b0, rf: 1'b0};
      CK_WR:   c = '{sel: 1'b1, wen: 1'b1, rf: 1'b0};
      CK_REF:  c = '{sel: 1'b1, wen: 1'b0, rf: 1'b1};
      default: c = '{sel: 1'b0, wen: 1'b0, rf: 1'b0};
    endcase
    return c;
  endfunction

  // Next bank in the refresh rotation.
  function automatic logic [7:0] next_bank(logic [7:0] b, int unsigned nbanks);
    return (32'(b) + 1 == nbanks) ? 8'd0 : b + 8'd1;
  endfunction

endpackage

// File: rtl/bank_busy_track.sv
module bank_busy_track #(
  parameter int NUM_BANKS = 8,
  parameter int TRC       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] load,
  output logic [NUM_BANKS-1:0] free
);
  localparam int CW = $clog2(TRC + 1);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (load[g])      cnt <= CW'(TRC - 1);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
    assign free[g] = (cnt == '0);
  end
endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
  import slot_issue_pkg::*;
#(
  parameter int REF_INT = 64,
  parameter int BANK_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_done,
  input  logic              issued,
  output logic              due,
  output logic [BANK_W-1:0] bank
);
  localparam int CW        = $clog2(REF_INT);
  localparam int NUM_BANKS = 1 << BANK_W;

  logic [CW-1:0] cnt;
  logic          expire;

  assign expire = (cnt == CW'(REF_INT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      due  <= 1'b0;
      bank <= '0;
    end else if (!cal_done) begin
      cnt <= '0;
      due <= 1'b0;
    end else begin
      cnt <= expire ? '0 : cnt + 1'b1;
      due <= (due && !issued) || expire;
      if (issued) bank <= BANK_W'(next_bank(8'(bank), NUM_BANKS));
    end
  end
endmodule

// File: rtl/wdata_delay.sv
module wdata_delay #(
  parameter int W   = 36,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_en,
  input  logic [W-1:0] in_word,
  output logic         out_en,
  output logic [W-1:0] out_word
);
  // Capture stage alongside the command register, then LAT more stages.
  localparam int STAGES = LAT + 1;

  logic [STAGES-1:0] v;
  logic [W-1:0]      pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v <= '0;
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      v       <= {v[STAGES-2:0], in_en};
      pipe[0] <= in_word;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign out_en   = v[STAGES-1];
  assign out_word = out_en ? pipe[STAGES-1] : '0;
endmodule

// File: rtl/cmd_slot_issuer.sv
module cmd_slot_issuer
  import slot_issue_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BANK_W  = 3,
  parameter int DQ_W    = 16,
  parameter int DM_W    = 2,
  parameter int TRC     = 4,
  parameter int REF_INT = 64,
  parameter int WD_LAT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_done,
  input  logic              bl4_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [2*DQ_W-1:0] wr_data,
  input  logic [2*DM_W-1:0] wr_mask,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic              rf_valid,
  output logic              rf_ready,
  input  logic [BANK_W-1:0] rf_bank,
  output logic              s0_sel,
  output logic              s0_wen,
  output logic              s0_ref,
  output logic [ADDR_W-1:0] s0_addr,
  output logic [BANK_W-1:0] s0_bank,
  output logic              s1_sel,
  output logic              s1_wen,
  output logic              s1_ref,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [BANK_W-1:0] s1_bank,
  output logic              wd_en0,
  output logic              wd_en1,
  output logic [DQ_W-1:0]   wd_data0,
  output logic [DQ_W-1:0]   wd_data1,
  output logic [DM_W-1:0]   wd_mask0,
  output logic [DM_W-1:0]   wd_mask1
);
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int WORD_W    = 2 * DQ_W + 2 * DM_W;

  // Named internal events, also observed by the checker.
  logic [NUM_BANKS-1:0] bank_free, bank_load;
  logic                 ref_due;
  logic [BANK_W-1:0]    due_bank;
  logic                 ref_go, wr_go, rd_go, rw_go, s0_go, rf_go;
  cmd_kind_e            s0_kind;
  logic [BANK_W-1:0]    s0_bank_n;
  logic [ADDR_W-1:0]    s0_addr_n;
  slot_ctl_t            s0_ctl_n;
  logic                 wd_en;
  logic [WORD_W-1:0]    wd_word;

  bank_busy_track #(.NUM_BANKS(NUM_BANKS), .TRC(TRC)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(bank_load), .free(bank_free)
  );

  refresh_pacer #(.REF_INT(REF_INT), .BANK_W(BANK_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .issued(ref_go),
    .due(ref_due), .bank(due_bank)
  );

  // Slot 0: due refresh, else write, else read.
  assign ref_go   = cal_done && ref_due && bank_free[due_bank];
  assign wr_ready = cal_done && !ref_due && bank_free[wr_bank];
  assign wr_go    = wr_valid && wr_ready;
  assign rd_ready = cal_done && !ref_due && !wr_go && bank_free[rd_bank];
  assign rd_go    = rd_valid && rd_ready;
  assign rw_go    = wr_go || rd_go;
  assign s0_go    = ref_go || rw_go;

  always_comb begin
    if (ref_go) begin
      s0_kind = CK_REF; s0_bank_n = due_bank; s0_addr_n = '0;
    end else if (wr_go) begin
      s0_kind = CK_WR;  s0_bank_n = wr_bank;  s0_addr_n = wr_addr;
    end else if (rd_go) begin
      s0_kind = CK_RD;  s0_bank_n = rd_bank;  s0_addr_n = rd_addr;
    end else begin
      s0_kind = CK_NOP; s0_bank_n = '0;       s0_addr_n = '0;
    end
  end

  assign s0_ctl_n = ctl_of(s0_kind);

  // Slot 1: user refresh only, on a different free bank, never beside a
  // read or write in burst-length-four mode.
  assign rf_ready = cal_done && bank_free[rf_bank] && !(rw_go && bl4_mode)
                    && !(s0_go && rf_bank == s0_bank_n);
  assign rf_go    = rf_valid && rf_ready;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      bank_load[b] = (s0_go && s0_bank_n == BANK_W'(b))
                  || (rf_go && rf_bank == BANK_W'(b));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s0_sel, s0_wen, s0_ref} <= '0;
      s0_addr <= '0;
      s0_bank <= '0;
      {s1_sel, s1_wen, s1_ref} <= '0;
      s1_addr <= '0;
      s1_bank <= '0;
    end else begin
      {s0_sel, s0_wen, s0_ref} <= s0_ctl_n;
      s0_addr <= s0_addr_n;
      s0_bank <= s0_bank_n;
      {s1_sel, s1_wen, s1_ref} <= ctl_of(rf_go ? CK_REF : CK_NOP);
      s1_addr <= '0;
      s1_bank <= rf_go ? rf_bank : '0;
    end
  end

  wdata_delay #(.W(WORD_W), .LAT(WD_LAT)) u_wdata (
    .clk(clk), .rst_n(rst_n), .in_en(wr_go), .in_word({wr_mask, wr_data}),
    .out_en(wd_en), .out_word(wd_word)
  );

  assign wd_en0   = wd_en;
  assign wd_en1   = wd_en;
  assign wd_data0 = wd_word[DQ_W-1:0];
  assign wd_data1 = wd_word[2*DQ_W-1:DQ_W];
  assign wd_mask0 = wd_word[2*DQ_W +: DM_W];
  assign wd_mask1 = wd_word[2*DQ_W+DM_W +: DM_W];
endmodule

// File: rtl/cmd_slot_issuer_chk.sv
module cmd_slot_issuer_chk #(
  parameter int BANK_W = 3,
  parameter int TRC    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_done,
  input logic              bl4_mode,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_ready,
  input logic              rf_ready,
  input logic              rw_go,
  input logic              ref_due,
  input logic              s0_sel,
  input logic              s0_wen,
  input logic              s0_ref,
  input logic [BANK_W-1:0] s0_bank,
  input logic              s1_sel,
  input logic              s1_wen,
  input logic              s1_ref,
  input logic [BANK_W-1:0] s1_bank,
  input logic              wd_en0,
  input logic              wd_en1
);
  localparam int NB = 1 << BANK_W;
  localparam int GW = $clog2(TRC + 1) + 1;

  // Cycles since each bank last appeared on a slot output, saturating at TRC.
  logic [NB-1:0] gap_bad;
  for (genvar g = 0; g < NB; g++) begin : g_gap
    logic [GW-1:0] since;
    logic          hit;
    assign hit = (s0_sel && s0_bank == BANK_W'(g)) || (s1_sel && s1_bank == BANK_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)                  since <= GW'(TRC);
      else if (hit)                since <= GW'(1);
      else if (since < GW'(TRC))   since <= since + 1'b1;
    end
    assign gap_bad[g] = hit && (since < GW'(TRC));
  end

  AST_IDLE_UNTIL_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_done |=> (!s0_sel && !s1_sel)); // R1
  AST_NO_READY_UNTIL_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_done |-> !(wr_ready || rd_ready || rf_ready)); // R1
  AST_WRITE_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_sel && s0_wen) |-> !s0_ref); // R2
  AST_SLOT1_REF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    s1_sel |-> (s1_ref && !s1_wen)); // R4
  AST_BL4_SLOT1_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_go && bl4_mode) |=> !s1_sel); // R5
  AST_WDATA_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_sel && s0_wen) |-> ##2 (wd_en0 && wd_en1)); // R6
  AST_WDATA_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en0 |-> $past(s0_sel && s0_wen, 2)); // R6
  AST_WRITE_OVER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> !rd_ready); // R7
  AST_REF_PAIR_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_ref && s1_ref) |-> (s0_bank != s1_bank)); // R8
  AST_BANK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    gap_bad == '0); // R9
  AST_DUE_STALLS_RW: assert property (@(posedge clk) disable iff (!rst_n)
    ref_due |-> (!wr_ready && !rd_ready)); // R10
endmodule

bind cmd_slot_issuer cmd_slot_issuer_chk #(.BANK_W(BANK_W), .TRC(TRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .bl4_mode(bl4_mode),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_ready(rd_ready),
  .rf_ready(rf_ready), .rw_go(rw_go), .ref_due(ref_due),
  .s0_sel(s0_sel), .s0_wen(s0_wen), .s0_ref(s0_ref), .s0_bank(s0_bank),
  .s1_sel(s1_sel), .s1_wen(s1_wen), .s1_ref(s1_ref), .s1_bank(s1_bank),
  .wd_en0(wd_en0), .wd_en1(wd_en1)
);

// File: tb/cmd_slot_issuer_bench.sv
module cmd_slot_issuer_bench;
  localparam int AW  = 20;
  localparam int BW  = 3;
  localparam int NB  = 8;
  localparam int DQ  = 16;
  localparam int DM  = 2;
  localparam int TRC = 4;
  localparam int RI  = 64;
  localparam int WW  = 2 * DQ + 2 * DM;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cal_done, bl4_mode;
  logic wr_valid, rd_valid, rf_valid;
  logic wr_ready, rd_ready, rf_ready;
  logic [AW-1:0] wr_addr, rd_addr, s0_addr, s1_addr;
  logic [BW-1:0] wr_bank, rd_bank, rf_bank, s0_bank, s1_bank;
  logic [2*DQ-1:0] wr_data;
  logic [2*DM-1:0] wr_mask;
  logic s0_sel, s0_wen, s0_ref, s1_sel, s1_wen, s1_ref, wd_en0, wd_en1;
  logic [DQ-1:0] wd_data0, wd_data1;
  logic [DM-1:0] wd_mask0, wd_mask1;

  cmd_slot_issuer u_cmd_slot_issuer (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state.
  int busy [NB];
  int tcnt, ptr, cyc;
  bit due;
  int last_use [NB];
  bit prev_rw_bl4;
  bit e_sel0, e_wen0, e_ref0, e_sel1, e_ref1;
  logic [AW-1:0] e_addr0;
  int e_bank0, e_bank1;
  typedef struct { bit v; logic [WW-1:0] w; } wh_t;
  wh_t hist[$];

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string s0_req();
    if (e_sel0 && e_wen0) return "R2";
    if (e_sel0 && e_ref0) return "R10";
    if (e_sel0)           return "R3";
    return "R4";
  endfunction

  task automatic compare_outputs();
    logic [WW-1:0] w;
    bit v;
    string r0;
    r0 = s0_req();
    chk(r0, "s0_sel", s0_sel, e_sel0);
    chk(r0, "s0_wen", s0_wen, e_wen0);
    chk(r0, "s0_ref", s0_ref, e_ref0);
    chk(r0, "s0_addr", s0_addr, e_addr0);
    chk(r0, "s0_bank", s0_bank, e_bank0);
    chk((e_ref0 && e_ref1) ? "R8" : "R4", "s1_sel", s1_sel, e_sel1);
    chk("R4", "s1_wen", s1_wen, 0);
    chk("R4", "s1_ref", s1_ref, e_ref1);
    chk("R4", "s1_addr", s1_addr, 0);
    chk("R8", "s1_bank", s1_bank, e_bank1);
    if (prev_rw_bl4) chk("R5", "slot1 beside bl4 read/write", s1_sel, 0);
    v = 0; w = '0;
    if (hist.size() >= 3) begin
      v = hist[hist.size()-3].v;
      w = v ? hist[hist.size()-3].w : '0;
    end
    chk("R6", "wd_en0", wd_en0, v);
    chk("R6", "wd_en1", wd_en1, v);
    chk("R6", "wd_data0", wd_data0, w[DQ-1:0]);
    chk("R6", "wd_data1", wd_data1, w[2*DQ-1:DQ]);
    chk("R6", "wd_mask0", wd_mask0, w[2*DQ +: DM]);
    chk("R6", "wd_mask1", wd_mask1, w[2*DQ+DM +: DM]);
    // Spacing seen at the slot outputs, counted independently.
    if (s0_sel) begin
      chk("R9", "slot0 bank spacing ok", (cyc - last_use[s0_bank]) >= TRC, 1);
      last_use[s0_bank] = cyc;
    end
    if (s1_sel) begin
      chk("R9", "slot1 bank spacing ok", (cyc - last_use[s1_bank]) >= TRC, 1);
      last_use[s1_bank] = cyc;
    end
    cyc++;
  endtask

  task automatic step(input bit cal, input bit bl4,
                      input bit wv, input int wb, input logic [AW-1:0] wa, input logic [WW-1:0] ww,
                      input bit rv, input int rb, input logic [AW-1:0] ra,
                      input bit fv, input int fb);
    bit wr_r, rd_r, rf_r, wgo, rgo, fgo, rfg, act0;
    int b0;
    @(negedge clk);
    compare_outputs();
    cal_done = cal; bl4_mode = bl4;
    wr_valid = wv; wr_bank = BW'(wb); wr_addr = wa;
    wr_data = ww[2*DQ-1:0]; wr_mask = ww[WW-1:2*DQ];
    rd_valid = rv; rd_bank = BW'(rb); rd_addr = ra;
    rf_valid = fv; rf_bank = BW'(fb);
    #1;
    rfg  = cal && due && busy[ptr] == 0;
    wr_r = cal && !due && busy[wb] == 0;
    wgo  = wv && wr_r;
    rd_r = cal && !due && !wgo && busy[rb] == 0;
    rgo  = rv && rd_r;
    act0 = rfg || wgo || rgo;
    b0   = rfg ? ptr : wgo ? wb : rgo ? rb : 0;
    rf_r = cal && busy[fb] == 0 && !((wgo || rgo) && bl4) && !(act0 && fb == b0);
    fgo  = fv && rf_r;
    chk(!cal ? "R1" : due ? "R10" : "R9", "wr_ready", wr_ready, wr_r);
    chk(!cal ? "R1" : due ? "R10" : "R7", "rd_ready", rd_ready, rd_r);
    chk(!cal ? "R1" : "R5", "rf_ready", rf_ready, rf_r);
    e_sel0 = act0; e_wen0 = wgo; e_ref0 = rfg;
    e_addr0 = wgo ? wa : rgo ? ra : '0;
    e_bank0 = b0;
    e_sel1 = fgo; e_ref1 = fgo; e_bank1 = fgo ? fb : 0;
    prev_rw_bl4 = (wgo || rgo) && bl4;
    for (int b = 0; b < NB; b++) begin
      if ((act0 && b0 == b) || (fgo && fb == b)) busy[b] = TRC - 1;
      else if (busy[b] > 0) busy[b]--;
    end
    if (!cal) begin
      tcnt = 0; due = 0;
    end else begin
      bit ex;
      ex   = (tcnt == RI - 1);
      tcnt = ex ? 0 : tcnt + 1;
      due  = (due && !rfg) || ex;
      if (rfg) ptr = (ptr + 1) % NB;
    end
    hist.push_back('{v: wgo, w: ww});
    if (hist.size() > 3) void'(hist.pop_front());
  endtask

  task automatic rand_step(input bit cal, input bit bl4, input int nbank);
    step(cal, bl4,
         ($urandom % 100) < 45, int'($urandom % nbank), AW'($urandom), WW'({$urandom, $urandom}),
         ($urandom % 100) < 55, int'($urandom % nbank), AW'($urandom),
         ($urandom % 100) < 30, int'($urandom % nbank));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired before the run completed");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cal_done = 0; bl4_mode = 0;
    wr_valid = 0; rd_valid = 0; rf_valid = 0;
    wr_addr = '0; rd_addr = '0; wr_bank = '0; rd_bank = '0; rf_bank = '0;
    wr_data = '0; wr_mask = '0;
    for (int b = 0; b < NB; b++) begin busy[b] = 0; last_use[b] = -100; end
    tcnt = 0; ptr = 0; due = 0; cyc = 0; prev_rw_bl4 = 0;
    e_sel0 = 0; e_wen0 = 0; e_ref0 = 0; e_addr0 = '0; e_bank0 = 0;
    e_sel1 = 0; e_ref1 = 0; e_bank1 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: every output idle (R1).
    chk("R1", "reset slot0 select", s0_sel, 0);
    chk("R1", "reset slot1 select", s1_sel, 0);
    chk("R1", "reset data enable", wd_en0, 0);
    chk("R1", "reset ready mask", {wr_ready, rd_ready, rf_ready}, 0);
    rst_n = 1;

    // R1: all channels valid while calibration is pending.
    for (int i = 0; i < 20; i++) step(0, 1, 1, i % NB, AW'(i), WW'(i), 1, (i + 1) % NB, AW'(i), 1, (i + 2) % NB);

    // Random traffic, burst-length-four slot rule (R5, R8, R9).
    for (int i = 0; i < 400; i++) rand_step(1, 1, 3);

    // R6: writes in consecutive cycles to distinct banks.
    for (int i = 0; i < 6; i++)
      step(1, 1, 1, i, AW'(32'h100 + i), WW'(36'h9_1234_0000 + i), 1, 7, AW'(5), 0, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, '0, '0, 0, 0, '0, 0, 0);

    // Random traffic, slot 1 free beside reads and writes.
    for (int i = 0; i < 400; i++) rand_step(1, 0, 4);

    // R10: calibration drops and returns; interval restarts.
    for (int i = 0; i < 8; i++) rand_step(0, 0, 4);
    for (int i = 0; i < 200; i++) rand_step(1, 0, 8);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, '0, '0, 0, 0, '0, 0, 0);
    @(negedge clk);
    compare_outputs();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule